// File: doc/BRIEF.md
# Self-test clock meter

This block lets a scan-chain port controller hand a parked local chain an exact number of test clocks, so that a target device on that chain can run its built-in self-test with nothing else on the backplane moving. A 32-bit value is scanned into a data register while the counter-select instruction is active. That value is copied into a down-counter at Update-DR. When the counter is switched on and the port is parked, the local clock enable is held high for exactly that many backplane clock cycles and then drops. A completion flag, which the neighbouring mode register presents as its bit 7, reports when the counter has reached zero.

The block runs on the backplane test clock `clk`. It takes the current TAP controller state as a 4-bit code, using the usual encoding: Test-Logic-Reset 4'hF, Run-Test/Idle 4'hC, Capture-DR 4'h6, Shift-DR 4'h2, Exit1-DR 4'h1, Update-DR 4'h5. The counter-on and counter-off commands are single-cycle pulses from the instruction decoder. `base_clk_en` is the clock enable that normal park and unpark control would give the port. This block either passes that enable through or overrides it. The data path is a bit-serial scan with no flow control, so the block has no valid/ready pins: every pin is a plain control or status signal, sampled once per clock.

Top module: `bist_tck_meter`

## Requirements
- R1: After `rst_n` is released, and on every clock edge at which `tap_state` is Test-Logic-Reset (4'hF), the counter and the shift register clear to zero and the counter is switched off, so `done` reads 1 and `tdo` reads 0.
- R2: At each clock edge with `cnt_sel` high and `tap_state` Shift-DR (4'h2), the shift register moves one place toward its least significant bit and takes `tdi` into its most significant bit. `tdo` always shows bit 0, so data enters and leaves least significant bit first.
- R3: At a clock edge with `cnt_sel` high and `tap_state` Update-DR (4'h5), the counter takes the shift register value. With `cnt_sel` low, Update-DR leaves the counter unchanged.
- R4: While the counter is switched on and non-zero, it decrements by one at every clock edge that does not load or clear it. While it is switched off, it holds its value.
- R5: While the counter is on and `parked` is high, `lclk_en` is high exactly when the counter is non-zero. After a load of N, it is therefore high for exactly N cycles, starting with the first cycle after Update-DR (this holds for N = 0, N = 1 and large N).
- R6: While the counter is off, or `parked` is low, `lclk_en` equals `base_clk_en`.
- R7: `done` is 1 exactly when the counter value is zero.
- R8: A `cmd_on` pulse switches the counter on and a `cmd_off` pulse switches it off, each from the next cycle; `cmd_off` wins if both are high. The edge at which `cmd_off` is sampled still decrements a running counter, and the counter then keeps its value.
- R9: At a clock edge with `cnt_sel` high and `tap_state` Capture-DR (4'h6), the shift register takes the counter value, so a following scan reads the remaining count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Backplane test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tap_state | input | 4 | Current TAP controller state code |
| cnt_sel | input | 1 | Counter-select instruction is active |
| tdi | input | 1 | Serial scan data in |
| cmd_on | input | 1 | Counter-on command pulse |
| cmd_off | input | 1 | Counter-off command pulse |
| parked | input | 1 | Local port is parked |
| base_clk_en | input | 1 | Clock enable from normal park/unpark control |
| tdo | output | 1 | Serial scan data out (shift register bit 0) |
| lclk_en | output | 1 | Local test clock enable |
| done | output | 1 | Counter has reached zero (mode register bit 7) |

## Verification
Every state change happens at a clock edge, and `lclk_en` is combinational from the state and from `parked` and `base_clk_en`. A load at the Update-DR edge is therefore visible in the very next cycle: `done` falls there and the first enabled local clock cycle appears there. A capture edge puts count bit 0 on `tdo` in the first Shift-DR cycle, and each shift edge moves the next bit up one cycle later. The bench drives its inputs just after a rising edge and samples one nanosecond later, before the next edge. It counts enabled cycles from the first cycle after Update-DR through several cycles beyond the expected end, so both a missing pulse and an extra pulse are caught.

// File: rtl/bist_meter_pkg.sv
package bist_meter_pkg;

  typedef enum logic [3:0] {
    TS_EXIT2_DR = 4'h0,
    TS_EXIT1_DR = 4'h1,
    TS_SHIFT_DR = 4'h2,
    TS_PAUSE_DR = 4'h3,
    TS_SEL_IR   = 4'h4,
    TS_UPD_DR   = 4'h5,
    TS_CAP_DR   = 4'h6,
    TS_SEL_DR   = 4'h7,
    TS_EXIT2_IR = 4'h8,
    TS_EXIT1_IR = 4'h9,
    TS_SHIFT_IR = 4'hA,
    TS_PAUSE_IR = 4'hB,
    TS_IDLE     = 4'hC,
    TS_UPD_IR   = 4'hD,
    TS_CAP_IR   = 4'hE,
    TS_RESET    = 4'hF
  } tap_state_e;

  typedef struct packed {
    logic clear;
    logic capture;
    logic shift;
    logic load;
  } scan_ctl_t;

endpackage

// File: rtl/bmt_scan_reg.sv
module bmt_scan_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         capture,
  input  logic         shift,
  input  logic         sin,
  input  logic [W-1:0] par_in,
  output logic [W-1:0] par_out,
  output logic         sout
);

  logic [W-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (clear) begin
      sr_q <= '0;
    end else if (capture) begin
      sr_q <= par_in;
    end else if (shift) begin
      sr_q <= {sin, sr_q[W-1:1]};
    end
  end

  assign par_out = sr_q;
  assign sout    = sr_q[0];

endmodule

// File: rtl/bmt_down_counter.sv
module bmt_down_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         arm_set,
  input  logic         arm_clr,
  output logic [W-1:0] cnt,
  output logic         armed,
  output logic         at_zero
);

  localparam logic [W-1:0] STEP = W'(1);

  logic [W-1:0] cnt_q;
  logic         armed_q;
  logic         zero_w;

  assign zero_w = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (armed_q && !zero_w) begin
      cnt_q <= cnt_q - STEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if (clear || arm_clr) begin
      armed_q <= 1'b0;
    end else if (arm_set) begin
      armed_q <= 1'b1;
    end
  end

  assign cnt     = cnt_q;
  assign armed   = armed_q;
  assign at_zero = zero_w;

endmodule

// File: rtl/bmt_clk_gate.sv
module bmt_clk_gate (
  input  logic armed,
  input  logic parked,
  input  logic at_zero,
  input  logic base_clk_en,
  output logic lclk_en
);

  always_comb begin
    if (armed && parked) begin
      lclk_en = !at_zero;
    end else begin
      lclk_en = base_clk_en;
    end
  end

endmodule

// File: rtl/bist_tck_meter.sv
module bist_tck_meter
  import bist_meter_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] tap_state,
  input  logic       cnt_sel,
  input  logic       tdi,
  input  logic       cmd_on,
  input  logic       cmd_off,
  input  logic       parked,
  input  logic       base_clk_en,
  output logic       tdo,
  output logic       lclk_en,
  output logic       done
);

  scan_ctl_t        ctl;
  logic [CNT_W-1:0] shreg;
  logic [CNT_W-1:0] cnt;
  logic             armed;
  logic             at_zero;

  always_comb begin
    ctl.clear   = (tap_state == TS_RESET);
    ctl.capture = cnt_sel && (tap_state == TS_CAP_DR);
    ctl.shift   = cnt_sel && (tap_state == TS_SHIFT_DR);
    ctl.load    = cnt_sel && (tap_state == TS_UPD_DR);
  end

  bmt_scan_reg #(.W(CNT_W)) u_scan (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (ctl.clear),
    .capture (ctl.capture),
    .shift   (ctl.shift),
    .sin     (tdi),
    .par_in  (cnt),
    .par_out (shreg),
    .sout    (tdo)
  );

  bmt_down_counter #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (ctl.clear),
    .load     (ctl.load),
    .load_val (shreg),
    .arm_set  (cmd_on),
    .arm_clr  (cmd_off),
    .cnt      (cnt),
    .armed    (armed),
    .at_zero  (at_zero)
  );

  bmt_clk_gate u_gate (
    .armed       (armed),
    .parked      (parked),
    .at_zero     (at_zero),
    .base_clk_en (base_clk_en),
    .lclk_en     (lclk_en)
  );

  assign done = at_zero;

endmodule

// File: rtl/bist_tck_meter_chk.sv
module bist_tck_meter_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       tap_state,
  input logic             cnt_sel,
  input logic             cmd_off,
  input logic             parked,
  input logic             base_clk_en,
  input logic             lclk_en,
  input logic             done,
  input logic             armed,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] shreg
);

  logic is_tlr;
  logic is_load;
  assign is_tlr  = (tap_state == 4'hF);
  assign is_load = cnt_sel && (tap_state == 4'h5);

  a_r1_tlr_clears: assert property (@(posedge clk) disable iff (!rst_n)
    is_tlr |=> (cnt == '0) && !armed && (shreg == '0));

  a_r3_update_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (is_load && !is_tlr) |=> cnt == $past(shreg));

  a_r4_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && (cnt != '0) && !is_load && !is_tlr) |=> cnt == $past(cnt) - CNT_W'(1));

  a_r4_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !is_load && !is_tlr) |=> $stable(cnt));

  a_r5_gated_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && parked && done) |-> !lclk_en);

  a_r5_running: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && parked && !done) |-> lclk_en);

  a_r6_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed || !parked) |-> (lclk_en == base_clk_en));

  a_r7_done_flag: assert property (@(posedge clk) disable iff (!rst_n)
    done == (cnt == '0));

  a_r8_off_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_off |=> !armed);

endmodule

bind bist_tck_meter bist_tck_meter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tap_state   (tap_state),
  .cnt_sel     (cnt_sel),
  .cmd_off     (cmd_off),
  .parked      (parked),
  .base_clk_en (base_clk_en),
  .lclk_en     (lclk_en),
  .done        (done),
  .armed       (armed),
  .cnt         (cnt),
  .shreg       (shreg)
);

// File: tb/bist_tck_meter_tb_top.sv
`timescale 1ns/1ps
module bist_tck_meter_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] tap_state = 4'hC;
  logic       cnt_sel = 1'b0;
  logic       tdi = 1'b0;
  logic       cmd_on = 1'b0;
  logic       cmd_off = 1'b0;
  logic       parked = 1'b0;
  logic       base_clk_en = 1'b0;
  logic       tdo;
  logic       lclk_en;
  logic       done;

  int errors = 0;
  int checks = 0;

  localparam logic [3:0] S_TLR = 4'hF, S_IDLE = 4'hC, S_CAP = 4'h6,
                         S_SHIFT = 4'h2, S_EX1 = 4'h1, S_UPD = 4'h5;

  always #10 clk = ~clk;

  bist_tck_meter dut_i (
    .clk(clk), .rst_n(rst_n), .tap_state(tap_state), .cnt_sel(cnt_sel),
    .tdi(tdi), .cmd_on(cmd_on), .cmd_off(cmd_off), .parked(parked),
    .base_clk_en(base_clk_en), .tdo(tdo), .lclk_en(lclk_en), .done(done)
  );

  function automatic logic exp_done(input logic [31:0] v);
    return (v == 32'd0);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic pulse_cmd(input logic on);
    if (on) cmd_on = 1'b1; else cmd_off = 1'b1;
    cyc();
    cmd_on = 1'b0;
    cmd_off = 1'b0;
  endtask

  // Capture, shift 32 bits (LSB first), exit, update; returns bits seen on tdo
  task automatic scan_dr(input logic [31:0] din, output logic [31:0] dout);
    tap_state = S_CAP;
    cyc();
    for (int i = 0; i < 32; i++) begin
      tap_state = S_SHIFT;
      tdi = din[i];
      #1 dout[i] = tdo;
      cyc();
    end
    tap_state = S_EX1;
    cyc();
    tap_state = S_UPD;
    cyc();
    tap_state = S_IDLE;
  endtask

  // From the first cycle after Update-DR, count cycles with lclk_en high
  task automatic count_pulses(input int span, output int n);
    n = 0;
    for (int k = 0; k < span; k++) begin
      #1 if (lclk_en) n++;
      cyc();
    end
  endtask

  task automatic burst_test(input logic [31:0] n_load, input string tag);
    logic [31:0] rb;
    int pulses;
    scan_dr(n_load, rb);
    #1 check({tag, " done after load"}, done, exp_done(n_load));
    count_pulses(int'(n_load) + 6, pulses);
    check({tag, " pulse count"}, pulses, n_load);
    #1 check("R7 done at end", done, 1);
    check("R5 gated at terminal count", lclk_en, 0);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] rb;
    logic [31:0] v;
    int unsigned seed;
    int pulses;
    seed = $urandom(32'd4242);
    tap_state = S_TLR;
    #25 rst_n = 1'b1;
    cyc();
    cyc();
    tap_state = S_IDLE;
    #1;
    check("R1 done after reset", done, 1);
    check("R1 tdo after reset", tdo, 0);
    check("R6 lclk follows base after reset", lclk_en, base_clk_en);

    // R2/R9 readback of zero and load of a pattern, counter off
    cnt_sel = 1'b1;
    v = 32'hA5C3_0F17;
    scan_dr(v, rb);
    check("R9 R2 readback of cleared count", rb, 0);
    #1 check("R3 done low after load", done, 0);
    for (int k = 0; k < 20; k++) begin
      base_clk_en = 1'($urandom);
      parked = 1'($urandom);
      #1 check("R6 lclk follows base while off", lclk_en, base_clk_en);
      cyc();
    end
    scan_dr(32'd0, rb);
    check("R4 R2 count held while off", rb, v);
    #1 check("R3 zero load gives done", done, 1);

    // R3: Update-DR without cnt_sel must not load
    cnt_sel = 1'b0;
    scan_dr(32'h0000_1234, rb);
    cnt_sel = 1'b1;
    #1 check("R3 no load without select", done, 1);
    scan_dr(32'd0, rb);
    check("R3 count still zero without select", rb, 0);

    // R5 metered bursts
    base_clk_en = 1'b0;
    parked = 1'b1;
    pulse_cmd(1'b1);
    #1 check("R5 no clock at zero when on", lclk_en, 0);
    burst_test(32'd0, "R5 N=0");
    burst_test(32'd1, "R5 N=1");
    burst_test(32'd1000, "R5 N=1000");
    for (int r = 0; r < 4; r++) begin
      v = ($urandom % 400) + 1;
      burst_test(v, "R5 random N");
    end

    // R4/R7 counting while not parked: lclk follows base, done after N
    parked = 1'b0;
    scan_dr(32'd30, rb);
    for (int k = 0; k < 30; k++) begin
      base_clk_en = 1'($urandom);
      #1 check("R6 lclk follows base unparked", lclk_en, base_clk_en);
      if (k == 29) check("R7 done low before zero", done, 0);
      cyc();
    end
    #1 check("R4 R7 counted to zero unparked", done, 1);

    // R8: switch off mid-burst
    parked = 1'b1;
    base_clk_en = 1'b0;
    scan_dr(32'd50, rb);
    count_pulses(10, pulses);
    check("R8 pulses before off", pulses, 10);
    cmd_off = 1'b1;
    #1 check("R8 still enabled in off cycle", lclk_en, 1);
    cyc();
    cmd_off = 1'b0;
    for (int k = 0; k < 6; k++) begin
      base_clk_en = 1'($urandom);
      #1 check("R8 lclk returns to base after off", lclk_en, base_clk_en);
      cyc();
    end
    #1 check("R8 done stays low after off", done, 0);
    base_clk_en = 1'b0;
    scan_dr(32'd0, rb);
    check("R8 R9 remaining count after off", rb, 39);

    // R8 both commands together: off wins
    cmd_on = 1'b1;
    cmd_off = 1'b1;
    cyc();
    cmd_on = 1'b0;
    cmd_off = 1'b0;
    scan_dr(32'd5, rb);
    count_pulses(8, pulses);
    check("R8 off wins over on", pulses, 0);

    // R1: Test-Logic-Reset clears count and switches off
    pulse_cmd(1'b1);
    scan_dr(32'd500, rb);
    count_pulses(3, pulses);
    tap_state = S_TLR;
    cyc();
    tap_state = S_IDLE;
    base_clk_en = 1'b1;
    #1 check("R1 done after TLR", done, 1);
    check("R1 counter off after TLR", lclk_en, 1);
    base_clk_en = 1'b0;
    #1 check("R1 counter off after TLR low", lclk_en, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule